// File: doc/BRIEF.md
# Four-Channel DMA Request Arbiter

This block sits between four peripherals that want direct memory access and the processor that owns the system bus. Each peripheral raises its request line whenever it has data to move. The arbiter brings these asynchronous lines into the clock domain and asks the processor for the bus through a hold request. Once the processor answers with a hold acknowledge, the arbiter picks one winning channel and drives that channel's active-low acknowledge. The transfer engine ends the service with a one-cycle end-of-service pulse. After that the arbiter either releases the bus or moves on to the next pending channel.

Two priority schemes are available through a mode input. In fixed mode the lowest channel number always wins. In rotating mode the channel that was just served drops to the bottom of the order, and the channel numbered after it moves to the top. There is no data path, so there is no valid/ready interface. Every pin is a plain control level or pulse.

Top module: `dma_req_arbiter`

## Requirements
- R1: Each request input passes through two synchronizing flops. A request raised between clock edges makes `hold_req` high after the third following rising edge, and not after the second.
- R2: `hold_req` goes high whenever a synchronized request is pending. While `hold_ack` stays low, every bit of `ack_n` stays at 1.
- R3: In the first cycle after `hold_ack` is sampled high with a request pending, exactly the winner's bit of `ack_n` is 0 (bit i belongs to channel i). `grant_idx` carries the winner's index as an unsigned binary number.
- R4: When `rotate_mode` is 0, the pending channel with the lowest index wins.
- R5: When `rotate_mode` is 1, the search for a winner starts at a top channel and wraps upward. The top channel is 0 after reset. Each service that ends with `rotate_mode` at 1 makes the served channel plus one (modulo 4) the new top channel.
- R6: Once a channel is acknowledged, `ack_n` and `grant_idx` hold their values until the end-of-service pulse is sampled. A new request, even one of higher priority, does not change them.
- R7: At most one bit of `ack_n` is 0 at any time. When one is 0, `grant_idx` names that bit.
- R8: In the cycle after `eos` is sampled high during a service, all `ack_n` bits return to 1. `hold_req` also drops in that cycle if no synchronized request remains, and stays high otherwise.
- R9: During and right after reset, `hold_req` is 0, `ack_n` is all ones and `grant_idx` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_async | input | 4 | Asynchronous per-channel service requests, active high |
| rotate_mode | input | 1 | 0 selects fixed priority, 1 selects rotating priority |
| hold_ack | input | 1 | Bus granted by the processor |
| eos | input | 1 | One-cycle end-of-service pulse from the transfer engine |
| hold_req | output | 1 | Bus request to the processor |
| ack_n | output | 4 | Per-channel acknowledge, active low |
| grant_idx | output | 2 | Index of the channel being served |

## Verification
A stuck or skipped controller state shows at the ports within one cycle of the stimulus that should move it. Examples are an acknowledge that appears before `hold_ack`, or a bus request that lingers one cycle past the final end-of-service. A corrupted rotation pointer does not show until the next arbitration. There it surfaces as the wrong channel going low, which a sequence of back-to-back services with all four requests held exposes at once. A winner register that updates during service shows up as an acknowledge that changes while no `eos` is present.

// File: rtl/dma_arb_pkg.sv
`timescale 1ns/1ps
package dma_arb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_REQ   = 2'd1,
    ST_SERVE = 2'd2
  } arb_state_t;
endpackage

// File: rtl/dmaarb_sync.sv
`timescale 1ns/1ps
module dmaarb_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) chain[0] <= '0;
    else        chain[0] <= d_async;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) chain[s] <= '0;
      else        chain[s] <= chain[s-1];
    end
  end

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/dmaarb_pick.sv
`timescale 1ns/1ps
// Circular search from a starting channel; first pending channel wins.
module dmaarb_pick #(
  parameter int N_CH = 4,
  localparam int CH_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic [N_CH-1:0] req,
  input  logic [CH_W-1:0] base,
  output logic            found,
  output logic [CH_W-1:0] idx
);
  always_comb begin
    logic [CH_W:0] cand;
    found = 1'b0;
    idx   = '0;
    for (int off = 0; off < N_CH; off++) begin
      cand = {1'b0, base} + (CH_W+1)'(off);
      if (cand >= (CH_W+1)'(N_CH)) cand = cand - (CH_W+1)'(N_CH);
      if (!found && req[cand[CH_W-1:0]]) begin
        found = 1'b1;
        idx   = cand[CH_W-1:0];
      end
    end
  end
endmodule

// File: rtl/dmaarb_ctrl.sv
`timescale 1ns/1ps
module dmaarb_ctrl
  import dma_arb_pkg::*;
#(
  parameter int N_CH = 4,
  localparam int CH_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_CH-1:0] req_s,
  input  logic            rotate_mode,
  input  logic            hold_ack,
  input  logic            eos,
  input  logic            pick_found,
  input  logic [CH_W-1:0] pick_idx,
  output logic [CH_W-1:0] search_base,
  output logic            hold_req,
  output logic [N_CH-1:0] ack_n,
  output logic [CH_W-1:0] grant_idx
);
  arb_state_t      state_q;
  logic [CH_W-1:0] winner_q;
  logic [CH_W-1:0] top_q;
  logic            any_req;
  logic [CH_W:0]   next_top;

  assign any_req     = |req_s;
  assign search_base = rotate_mode ? top_q : '0;

  always_comb begin
    next_top = {1'b0, winner_q} + 1'b1;
    if (next_top >= (CH_W+1)'(N_CH)) next_top = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      winner_q <= '0;
      top_q    <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (any_req) state_q <= ST_REQ;
        end
        ST_REQ: begin
          if (!any_req) begin
            state_q <= ST_IDLE;
          end else if (hold_ack && pick_found) begin
            winner_q <= pick_idx;
            state_q  <= ST_SERVE;
          end
        end
        ST_SERVE: begin
          if (eos) begin
            if (rotate_mode) top_q <= next_top[CH_W-1:0];
            state_q <= any_req ? ST_REQ : ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign hold_req  = (state_q != ST_IDLE);
  assign grant_idx = winner_q;

  for (genvar c = 0; c < N_CH; c++) begin : g_ack
    assign ack_n[c] = !((state_q == ST_SERVE) && (winner_q == CH_W'(c)));
  end
endmodule

// File: rtl/dma_req_arbiter.sv
`timescale 1ns/1ps
module dma_req_arbiter #(
  parameter int N_CH        = 4,
  parameter int SYNC_STAGES = 2,
  localparam int CH_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_CH-1:0] req_async,
  input  logic            rotate_mode,
  input  logic            hold_ack,
  input  logic            eos,
  output logic            hold_req,
  output logic [N_CH-1:0] ack_n,
  output logic [CH_W-1:0] grant_idx
);
  logic [N_CH-1:0] req_s;
  logic [CH_W-1:0] base;
  logic            found;
  logic [CH_W-1:0] pidx;

  dmaarb_sync #(.WIDTH(N_CH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(req_async), .q_sync(req_s)
  );

  dmaarb_pick #(.N_CH(N_CH)) u_pick (
    .req(req_s), .base(base), .found(found), .idx(pidx)
  );

  dmaarb_ctrl #(.N_CH(N_CH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_s(req_s), .rotate_mode(rotate_mode),
    .hold_ack(hold_ack), .eos(eos), .pick_found(found), .pick_idx(pidx),
    .search_base(base), .hold_req(hold_req), .ack_n(ack_n),
    .grant_idx(grant_idx)
  );
endmodule

// File: rtl/dma_req_arbiter_chk.sv
`timescale 1ns/1ps
module dma_req_arbiter_chk #(
  parameter int N_CH = 4,
  localparam int CH_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            hold_ack,
  input logic            eos,
  input logic            hold_req,
  input logic [N_CH-1:0] ack_n,
  input logic [CH_W-1:0] grant_idx
);
  p_one_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~ack_n) <= 1);

  p_idx_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_n != '1) |-> (ack_n[grant_idx] == 1'b0));

  p_ack_after_hlda_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((ack_n != '1) && ($past(ack_n) == '1)) |-> $past(hold_ack));

  p_ack_needs_hrq_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_n != '1) |-> hold_req);

  p_no_preempt_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(ack_n) != '1) && !$past(eos)) |-> (ack_n == $past(ack_n)));

  p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(ack_n) != '1) && $past(eos)) |-> (ack_n == '1));
endmodule

bind dma_req_arbiter dma_req_arbiter_chk #(.N_CH(N_CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .hold_ack(hold_ack), .eos(eos),
  .hold_req(hold_req), .ack_n(ack_n), .grant_idx(grant_idx)
);

// File: tb/tb_dma_req_arbiter.sv
`timescale 1ns/1ps
module tb_dma_req_arbiter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] req_async = '0;
  logic       rotate_mode = 1'b0;
  logic       hold_ack = 1'b0;
  logic       eos = 1'b0;
  logic       hold_req;
  logic [3:0] ack_n;
  logic [1:0] grant_idx;

  int checks = 0;
  int failures = 0;
  int exp_q[$];
  bit done = 0;

  always #4 clk = ~clk;

  dma_req_arbiter dut (
    .clk(clk), .rst_n(rst_n), .req_async(req_async), .rotate_mode(rotate_mode),
    .hold_ack(hold_ack), .eos(eos), .hold_req(hold_req), .ack_n(ack_n),
    .grant_idx(grant_idx)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: every new acknowledge is compared with the scoreboard head.
  logic [3:0] prev_ack = 4'hF;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (prev_ack == 4'hF && ack_n != 4'hF) begin
        if (exp_q.size() == 0) begin
          check(0, "R3 unexpected grant", int'(ack_n), 15);
        end else begin
          int e;
          e = exp_q.pop_front();
          check(ack_n == ~(4'b1 << e), "R3/R4/R5 grant ack_n", int'(ack_n), int'(~(4'b1 << e) & 4'hF));
          check(grant_idx == 2'(e), "R3/R7 grant_idx", int'(grant_idx), e);
        end
      end
      prev_ack = ack_n;
    end
  end

  // One service: grant exp, optional intruding request, finish, optional re-raise.
  task automatic serve(input int exp, input bit reraise, input int intruder);
    logic [3:0] exp_ack;
    bit others;
    exp_ack = ~(4'b1 << exp);
    repeat (3) @(negedge clk);
    for (int t = 0; t < 20 && !hold_req; t++) @(negedge clk);
    check(hold_req == 1'b1, "R2 hold_req before grant", int'(hold_req), 1);
    check(ack_n == 4'hF, "R2 no ack without hold_ack", int'(ack_n), 15);
    exp_q.push_back(exp);
    hold_ack = 1'b1;
    @(negedge clk);
    check(ack_n == exp_ack, "R3 ack one cycle after hold_ack", int'(ack_n), int'(exp_ack));
    if (intruder >= 0) req_async[intruder] = 1'b1;
    req_async[exp] = 1'b0;
    repeat (5) @(negedge clk);
    check(ack_n == exp_ack && grant_idx == 2'(exp), "R6 grant held during service",
          int'(ack_n), int'(exp_ack));
    others = (req_async != 4'h0);
    eos = 1'b1; hold_ack = 1'b0;
    @(negedge clk);
    eos = 1'b0;
    check(ack_n == 4'hF, "R8 acks released after eos", int'(ack_n), 15);
    check(hold_req == others, "R8 hold_req after eos", int'(hold_req), int'(others));
    if (reraise) req_async[exp] = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(0, "watchdog (all requirements)", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(hold_req == 0 && ack_n == 4'hF && grant_idx == 0, "R9 state in reset",
          int'({hold_req, ack_n, grant_idx}), 'h3C);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(hold_req == 0 && ack_n == 4'hF && grant_idx == 0, "R9 state after reset",
          int'({hold_req, ack_n, grant_idx}), 'h3C);

    // R1: synchronizer latency
    req_async = 4'b1010;
    repeat (2) @(negedge clk);
    check(hold_req == 1'b0, "R1 hold_req not after two edges", int'(hold_req), 0);
    @(negedge clk);
    check(hold_req == 1'b1, "R1 hold_req after three edges", int'(hold_req), 1);
    repeat (4) @(negedge clk);
    check(ack_n == 4'hF, "R2 no ack while hold_ack low", int'(ack_n), 15);

    // R4: fixed priority, channels 1 and 3 pending
    serve(1, 0, -1);
    serve(3, 0, -1);          // none left: R8 drop
    // R4 with all four held: channel 0 keeps winning
    req_async = 4'b1111;
    serve(0, 1, -1);
    serve(0, 1, -1);
    req_async = 4'b0000;
    repeat (6) @(negedge clk);
    check(hold_req == 1'b0, "R2 hold_req falls with no request", int'(hold_req), 0);

    // R6: lower-index request arrives during service of channel 2
    req_async = 4'b0100;
    serve(2, 0, 0);
    serve(0, 0, -1);

    // R5: rotating, all four held, top starts at 0
    rotate_mode = 1'b1;
    req_async = 4'b1111;
    serve(0, 1, -1);
    serve(1, 1, -1);
    serve(2, 1, -1);
    serve(3, 1, -1);
    serve(0, 1, -1);
    // R5: after serving 0, top is 1; only channels 0 and 3 pending -> 3 first
    req_async = 4'b1001;
    serve(3, 0, -1);
    serve(0, 0, -1);
    // R4: back to fixed mode, lowest index wins despite top pointer
    rotate_mode = 1'b0;
    req_async = 4'b0110;
    serve(1, 0, -1);
    serve(2, 0, -1);

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R3 all expected grants seen", exp_q.size(), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule